// File: doc/BRIEF.md
# LUT Refill Engine

This block fills a two-dimensional page-address lookup table from chains of descriptors held in memory. Each refill engine is started by writing the address of the first descriptor into its own descriptor register. The engine then fetches a four-word descriptor. The descriptor names a target table, an inclusive rectangular window of slots, a pointer to an array of 32-bit page addresses, and the address of the next descriptor. The engine reads the array one word at a time and writes each word into the table. It walks the window row by row. When it finishes a window it moves on to the next descriptor. A next pointer of zero ends the chain.

Software first writes 0 to the descriptor register, which cancels any pending work. It then waits until the engine's status shows READY, and then writes the start address. Several engines share one memory read port, which allows only one read in flight, and one table write port. When an engine finishes its last descriptor it raises an end-of-list bit in a shared interrupt status register. When it finds a malformed descriptor it raises an error bit instead. A per-engine slice of an enable register gates both bits onto a single interrupt line.

Register map (byte offsets): 0x00 interrupt status (write 1 to clear), 0x04 interrupt enable, 0x20+8e descriptor register of engine e, 0x24+8e status of engine e. The status register has bit 0 = READY and bit 1 = ERR. In the interrupt registers, bit 4e is the end-of-list bit of engine e and bit 4e+1 is its error bit.

Top module: `lut_refill`

## Requirements
- R1: After reset every engine status reads READY=1 and ERR=0, the interrupt status reads 0, and irq_o is low.
- R2: A descriptor is four 32-bit words at a 16-byte aligned address. Byte +0 holds the next pointer. Byte +4 holds the control word, whose low LUT_ID_W bits select the table. Byte +8 holds the area, with x0 in bits [7:0], x1 in [15:8], y0 in [23:16] and y1 in [31:24]. Byte +12 holds the data pointer.
- R3: For an area of width w = x1-x0+1, data word k (at data pointer + 4k) is written to row y0 + k/w, column x0 + k%w of the selected table. The writes come in increasing k.
- R4: A nonzero next pointer makes the engine continue with that descriptor. A zero next pointer ends the chain.
- R5: READY is low from the cycle after a start until the cycle after the last table write of the chain. It is high again one cycle after that write.
- R6: Completion of a chain sets interrupt status bit 4e. Writing 1 to a status bit clears it.
- R7: A start, next or data pointer whose low 4 bits are not zero sets ERR and interrupt bit 4e+1. The engine stops without the end-of-list bit and without writing any entry of that descriptor.
- R8: A descriptor with x1 < x0 or y1 < y0 sets ERR and interrupt bit 4e+1. It stops the chain with no table write and no end-of-list bit.
- R9: Writing 0 to the descriptor register returns the engine to READY with ERR cleared. No further table writes and no end-of-list bit follow.
- R10: A nonzero write to the descriptor register while the engine is busy is ignored. The running chain completes unchanged.
- R11: Across all engines, at most one memory read is in flight at a time. When several engines compete, the lowest-numbered engine wins the read and write ports.
- R12: irq_o is the OR of the interrupt status bits ANDed with the enable bits. Status bits are recorded even while they are disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on reg_addr_i) |
| irq_o | output | 1 | Interrupt request |
| mem_req_o | output | 1 | One-cycle memory read request |
| mem_addr_o | output | 32 | Memory read byte address |
| mem_rvalid_i | input | 1 | Read data valid, one per request |
| mem_rdata_i | input | 32 | Read data |
| lut_we_o | output | 1 | Table write strobe |
| lut_sel_o | output | LUT_ID_W | Target table |
| lut_row_o | output | 8 | Table row |
| lut_col_o | output | 8 | Table column |
| lut_data_o | output | 32 | Page address written |

## Verification
The assertions assume that the memory answers every request with exactly one mem_rvalid_i pulse, returns none without a request, and takes at least one cycle to answer. The bench memory model has a fixed two-cycle latency and it counts any request that arrives while another is still outstanding. The assertions also assume that software follows the cancel, poll, start order. The bench always cancels, polls for READY and only then starts. It issues one deliberate start during a busy chain to show that such a start is ignored. All descriptors and data arrays sit in a 4 KB modelled memory. Each test uses its own table select values, so the scoreboard can tell the writes of two engines apart.

// File: rtl/lre_pkg.sv
package lre_pkg;
  typedef enum logic [1:0] {E_IDLE, E_RREQ, E_RWAIT, E_LWR} eng_state_e;

  localparam int unsigned COORD_W      = 8;
  localparam logic [7:0]  REG_IRQ_STAT = 8'h00;
  localparam logic [7:0]  REG_IRQ_EN   = 8'h04;
  localparam int unsigned REG_ENG_BASE = 32'h20;

  function automatic logic [7:0] eng_desc_off(input int unsigned e);
    return 8'(REG_ENG_BASE + 8 * e);
  endfunction

  function automatic logic [7:0] eng_stat_off(input int unsigned e);
    return 8'(REG_ENG_BASE + 8 * e + 4);
  endfunction
endpackage

// File: rtl/lre_arb.sv
module lre_arb #(
  parameter int unsigned N = 2
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // fixed priority: lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/lre_regs.sv
module lre_regs
  import lre_pkg::*;
#(
  parameter int unsigned N_ENG = 2,
  localparam int unsigned IRQ_W = 4 * N_ENG
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [7:0]       addr_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  logic [N_ENG-1:0] ready_i,
  input  logic [N_ENG-1:0] err_i,
  input  logic [N_ENG-1:0] eol_i,
  input  logic [N_ENG-1:0] fault_i,
  output logic [N_ENG-1:0] start_o,
  output logic [N_ENG-1:0] cancel_o,
  output logic             irq_o
);
  logic [IRQ_W-1:0] irq_stat_q, irq_en_q, set_v, clr_v;
  logic [31:0]      desc_q [N_ENG];
  logic [N_ENG-1:0] hit_v;

  always_comb begin
    set_v = '0;
    hit_v = '0;
    for (int unsigned e = 0; e < N_ENG; e++) begin
      set_v[4*e]   = eol_i[e];
      set_v[4*e+1] = fault_i[e];
      hit_v[e]     = we_i && (addr_i == eng_desc_off(e));
    end
  end

  assign clr_v    = (we_i && addr_i == REG_IRQ_STAT) ? wdata_i[IRQ_W-1:0] : '0;
  assign start_o  = hit_v & {N_ENG{wdata_i != 32'd0}};
  assign cancel_o = hit_v & {N_ENG{wdata_i == 32'd0}};
  assign irq_o    = |(irq_stat_q & irq_en_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_stat_q <= '0;
      irq_en_q   <= '0;
      for (int unsigned e = 0; e < N_ENG; e++) desc_q[e] <= '0;
    end else begin
      irq_stat_q <= (irq_stat_q & ~clr_v) | set_v;
      if (we_i && addr_i == REG_IRQ_EN) irq_en_q <= wdata_i[IRQ_W-1:0];
      for (int unsigned e = 0; e < N_ENG; e++)
        if (hit_v[e]) desc_q[e] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == REG_IRQ_STAT) rdata_o = 32'(irq_stat_q);
    if (addr_i == REG_IRQ_EN)   rdata_o = 32'(irq_en_q);
    for (int unsigned e = 0; e < N_ENG; e++) begin
      if (addr_i == eng_desc_off(e)) rdata_o = desc_q[e];
      if (addr_i == eng_stat_off(e)) rdata_o = {30'd0, err_i[e], ready_i[e]};
    end
  end

  // R6: a write-one-to-clear with no new event leaves the written bits clear
  p_w1c_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == REG_IRQ_STAT && set_v == '0)
      |=> ((irq_stat_q & $past(wdata_i[IRQ_W-1:0])) == '0));
endmodule

// File: rtl/lre_engine.sv
module lre_engine
  import lre_pkg::*;
#(
  parameter int unsigned LUT_ID_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                start_i,
  input  logic                cancel_i,
  input  logic [31:0]         start_addr_i,
  output logic                rd_req_o,
  output logic [31:0]         rd_addr_o,
  input  logic                rd_gnt_i,
  input  logic                rd_valid_i,
  input  logic [31:0]         rd_data_i,
  output logic                wr_req_o,
  input  logic                wr_gnt_i,
  output logic [LUT_ID_W-1:0] wr_sel_o,
  output logic [COORD_W-1:0]  wr_row_o,
  output logic [COORD_W-1:0]  wr_col_o,
  output logic [31:0]         wr_data_o,
  output logic                ready_o,
  output logic                err_o,
  output logic                eol_o,
  output logic                fault_o
);
  eng_state_e          state_q;
  logic                in_desc_q, err_q, eol_q, fault_q;
  logic [1:0]          widx_q;
  logic [31:0]         cur_q, nxt_q, dptr_q, data_q;
  logic [LUT_ID_W-1:0] sel_q;
  logic [COORD_W-1:0]  x0_q, x1_q, y0_q, y1_q, row_q, col_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= E_IDLE;
      in_desc_q <= 1'b0;
      err_q     <= 1'b0;
      eol_q     <= 1'b0;
      fault_q   <= 1'b0;
      widx_q    <= '0;
      cur_q     <= '0;
      nxt_q     <= '0;
      dptr_q    <= '0;
      data_q    <= '0;
      sel_q     <= '0;
      x0_q      <= '0;
      x1_q      <= '0;
      y0_q      <= '0;
      y1_q      <= '0;
      row_q     <= '0;
      col_q     <= '0;
    end else begin
      eol_q   <= 1'b0;
      fault_q <= 1'b0;
      if (cancel_i) begin
        state_q <= E_IDLE;
        err_q   <= 1'b0;
      end else begin
        unique case (state_q)
          E_IDLE: if (start_i) begin
            if (start_addr_i[3:0] != 4'd0) begin
              err_q   <= 1'b1;
              fault_q <= 1'b1;
            end else begin
              err_q     <= 1'b0;
              cur_q     <= start_addr_i;
              in_desc_q <= 1'b1;
              widx_q    <= '0;
              state_q   <= E_RREQ;
            end
          end
          E_RREQ: if (rd_gnt_i) state_q <= E_RWAIT;
          E_RWAIT: if (rd_valid_i) begin
            if (in_desc_q) begin
              unique case (widx_q)
                2'd0: nxt_q <= rd_data_i;
                2'd1: sel_q <= rd_data_i[LUT_ID_W-1:0];
                2'd2: {y1_q, y0_q, x1_q, x0_q} <= rd_data_i;
                default: dptr_q <= rd_data_i;
              endcase
              if (widx_q == 2'd3) begin
                if (x1_q < x0_q || y1_q < y0_q || rd_data_i[3:0] != 4'd0) begin
                  err_q   <= 1'b1;
                  fault_q <= 1'b1;
                  state_q <= E_IDLE;
                end else begin
                  in_desc_q <= 1'b0;
                  row_q     <= y0_q;
                  col_q     <= x0_q;
                  state_q   <= E_RREQ;
                end
              end else begin
                widx_q  <= widx_q + 2'd1;
                state_q <= E_RREQ;
              end
            end else begin
              data_q  <= rd_data_i;
              dptr_q  <= dptr_q + 32'd4;
              state_q <= E_LWR;
            end
          end
          E_LWR: if (wr_gnt_i) begin
            if (col_q == x1_q) begin
              if (row_q == y1_q) begin
                if (nxt_q == 32'd0) begin
                  eol_q   <= 1'b1;
                  state_q <= E_IDLE;
                end else if (nxt_q[3:0] != 4'd0) begin
                  err_q   <= 1'b1;
                  fault_q <= 1'b1;
                  state_q <= E_IDLE;
                end else begin
                  cur_q     <= nxt_q;
                  in_desc_q <= 1'b1;
                  widx_q    <= '0;
                  state_q   <= E_RREQ;
                end
              end else begin
                row_q   <= row_q + 1'b1;
                col_q   <= x0_q;
                state_q <= E_RREQ;
              end
            end else begin
              col_q   <= col_q + 1'b1;
              state_q <= E_RREQ;
            end
          end
          default: state_q <= E_IDLE;
        endcase
      end
    end
  end

  assign rd_req_o  = (state_q == E_RREQ);
  assign rd_addr_o = in_desc_q ? cur_q + {28'd0, widx_q, 2'b00} : dptr_q;
  assign wr_req_o  = (state_q == E_LWR);
  assign wr_sel_o  = sel_q;
  assign wr_row_o  = row_q;
  assign wr_col_o  = col_q;
  assign wr_data_o = data_q;
  assign ready_o   = (state_q == E_IDLE);
  assign err_o     = err_q;
  assign eol_o     = eol_q;
  assign fault_o   = fault_q;

  p_desc_aligned_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && in_desc_q && widx_q == 2'd0) |-> (rd_addr_o[3:0] == 4'd0));

  p_in_area_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_req_o |-> (col_q >= x0_q && col_q <= x1_q && row_q >= y0_q && row_q <= y1_q));

  p_ready_after_write_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_req_o && wr_gnt_i && !cancel_i && col_q == x1_q && row_q == y1_q && nxt_q == 32'd0)
      |=> (ready_o && eol_o));

  p_fault_no_eol_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (!eol_o && err_o));
endmodule

// File: rtl/lut_refill.sv
module lut_refill
  import lre_pkg::*;
#(
  parameter int unsigned N_ENG    = 2,
  parameter int unsigned LUT_ID_W = 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                reg_we_i,
  input  logic [7:0]          reg_addr_i,
  input  logic [31:0]         reg_wdata_i,
  output logic [31:0]         reg_rdata_o,
  output logic                irq_o,
  output logic                mem_req_o,
  output logic [31:0]         mem_addr_o,
  input  logic                mem_rvalid_i,
  input  logic [31:0]         mem_rdata_i,
  output logic                lut_we_o,
  output logic [LUT_ID_W-1:0] lut_sel_o,
  output logic [7:0]          lut_row_o,
  output logic [7:0]          lut_col_o,
  output logic [31:0]         lut_data_o
);
  logic [N_ENG-1:0]    start, cancel, ready, err, eol, fault;
  logic [N_ENG-1:0]    rd_req, rd_arb_req, rd_gnt, rd_valid, rd_own_q;
  logic [N_ENG-1:0]    wr_req, wr_gnt;
  logic [31:0]         rd_addr [N_ENG];
  logic [31:0]         wr_data [N_ENG];
  logic [COORD_W-1:0]  wr_row  [N_ENG];
  logic [COORD_W-1:0]  wr_col  [N_ENG];
  logic [LUT_ID_W-1:0] wr_sel  [N_ENG];
  logic                rd_busy;

  lre_regs #(.N_ENG(N_ENG)) u_regs (
    .clk_i, .rst_ni,
    .we_i(reg_we_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o),
    .ready_i(ready), .err_i(err), .eol_i(eol), .fault_i(fault),
    .start_o(start), .cancel_o(cancel), .irq_o(irq_o)
  );

  for (genvar e = 0; e < N_ENG; e++) begin : g_eng
    lre_engine #(.LUT_ID_W(LUT_ID_W)) u_eng (
      .clk_i, .rst_ni,
      .start_i(start[e]), .cancel_i(cancel[e]), .start_addr_i(reg_wdata_i),
      .rd_req_o(rd_req[e]), .rd_addr_o(rd_addr[e]), .rd_gnt_i(rd_gnt[e]),
      .rd_valid_i(rd_valid[e]), .rd_data_i(mem_rdata_i),
      .wr_req_o(wr_req[e]), .wr_gnt_i(wr_gnt[e]), .wr_sel_o(wr_sel[e]),
      .wr_row_o(wr_row[e]), .wr_col_o(wr_col[e]), .wr_data_o(wr_data[e]),
      .ready_o(ready[e]), .err_o(err[e]), .eol_o(eol[e]), .fault_o(fault[e])
    );
  end

  // read port: locked to one owner until its data returns
  assign rd_busy    = |rd_own_q;
  assign rd_arb_req = rd_busy ? '0 : rd_req;
  assign rd_valid   = rd_own_q & {N_ENG{mem_rvalid_i}};

  lre_arb #(.N(N_ENG)) u_rd_arb (.req_i(rd_arb_req), .gnt_o(rd_gnt));
  lre_arb #(.N(N_ENG)) u_wr_arb (.req_i(wr_req),     .gnt_o(wr_gnt));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           rd_own_q <= '0;
    else if (mem_rvalid_i) rd_own_q <= '0;
    else if (|rd_gnt)      rd_own_q <= rd_gnt;
  end

  always_comb begin
    mem_req_o  = |rd_gnt;
    mem_addr_o = '0;
    lut_we_o   = |wr_gnt;
    lut_sel_o  = '0;
    lut_row_o  = '0;
    lut_col_o  = '0;
    lut_data_o = '0;
    for (int unsigned e = 0; e < N_ENG; e++) begin
      if (rd_gnt[e]) mem_addr_o = rd_addr[e];
      if (wr_gnt[e]) begin
        lut_sel_o  = wr_sel[e];
        lut_row_o  = wr_row[e];
        lut_col_o  = wr_col[e];
        lut_data_o = wr_data[e];
      end
    end
  end

  p_single_read_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o);

  p_no_orphan_data_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rvalid_i |-> rd_busy);
endmodule

// File: tb/lut_refill_bench.sv
module lut_refill_bench;
  localparam int N_ENG = 2;
  localparam int LID_W = 2;
  localparam int MEM_LAT = 2;
  localparam logic [7:0] A_IST = 8'h00, A_IEN = 8'h04;
  localparam logic [7:0] A_D0 = 8'h20, A_S0 = 8'h24, A_D1 = 8'h28, A_S1 = 8'h2C;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic             reg_we = 1'b0;
  logic [7:0]       reg_addr = '0;
  logic [31:0]      reg_wdata = '0, reg_rdata;
  logic             irq, mem_req, lut_we;
  logic [31:0]      mem_addr, lut_data;
  logic             mem_rvalid = 1'b0;
  logic [31:0]      mem_rdata = '0;
  logic [LID_W-1:0] lut_sel;
  logic [7:0]       lut_row, lut_col;

  lut_refill #(.N_ENG(N_ENG), .LUT_ID_W(LID_W)) u_lut_refill (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_we_i(reg_we), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .irq_o(irq), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .lut_we_o(lut_we), .lut_sel_o(lut_sel), .lut_row_o(lut_row), .lut_col_o(lut_col),
    .lut_data_o(lut_data)
  );

  int total = 0, bad = 0;
  int wr_count = 0, dbl_req = 0;
  bit sb_on = 1'b1;
  logic [31:0] mem [0:1023];
  logic [47:0] q0[$], q1[$], q2[$], q3[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: fixed latency, counts overlapping requests
  logic pend = 1'b0;
  logic [31:0] paddr = '0;
  int pcnt = 0;
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (pend) begin
      if (pcnt == 0) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem[paddr[11:2]];
        pend       <= 1'b0;
      end else pcnt <= pcnt - 1;
    end
    if (mem_req) begin
      if (pend) dbl_req <= dbl_req + 1;
      pend  <= 1'b1;
      paddr <= mem_addr;
      pcnt  <= MEM_LAT - 1;
    end
  end

  // scoreboard monitor (R3)
  always @(negedge clk) begin
    if (rst_n && lut_we) begin
      logic [47:0] got, exp;
      bit have;
      wr_count++;
      if (sb_on) begin
        got = {lut_row, lut_col, lut_data};
        have = 1'b0;
        exp = '0;
        case (lut_sel)
          2'd0: if (q0.size() > 0) begin exp = q0.pop_front(); have = 1'b1; end
          2'd1: if (q1.size() > 0) begin exp = q1.pop_front(); have = 1'b1; end
          2'd2: if (q2.size() > 0) begin exp = q2.pop_front(); have = 1'b1; end
          default: if (q3.size() > 0) begin exp = q3.pop_front(); have = 1'b1; end
        endcase
        chk(have, "R3 unexpected write", {16'd0, lut_row, lut_col}, 32'd0);
        if (have) begin
          chk(got[47:32] == exp[47:32], "R3 row/col", {16'd0, got[47:32]}, {16'd0, exp[47:32]});
          chk(got[31:0] == exp[31:0], "R3 data", got[31:0], exp[31:0]);
        end
      end
    end
  end

  task automatic push_exp(input int sel, input logic [47:0] it);
    case (sel)
      0: q0.push_back(it);
      1: q1.push_back(it);
      2: q2.push_back(it);
      default: q3.push_back(it);
    endcase
  endtask

  function automatic int qlen();
    return q0.size() + q1.size() + q2.size() + q3.size();
  endfunction

  // R2 layout: next, ctrl, area {y1,y0,x1,x0}, data pointer
  task automatic mk_desc(input int a, input logic [31:0] nxt, input int sel,
                         input int x0, input int x1, input int y0, input int y1,
                         input logic [31:0] dp, input logic [31:0] base, input bit push);
    mem[a/4]     = nxt;
    mem[a/4 + 1] = 32'(sel);
    mem[a/4 + 2] = {y1[7:0], y0[7:0], x1[7:0], x0[7:0]};
    mem[a/4 + 3] = dp;
    if (x1 >= x0 && y1 >= y0) begin
      for (int r = 0; r <= y1 - y0; r++) begin
        for (int c = 0; c <= x1 - x0; c++) begin
          int k;
          k = r * (x1 - x0 + 1) + c;
          mem[int'(dp / 4) + k] = base + 32'(k);
          if (push) push_exp(sel, {8'(y0 + r), 8'(x0 + c), base + 32'(k)});
        end
      end
    end
  endtask

  task automatic rw(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  // waits for READY; returns whether a table write happened in the cycle before
  task automatic run_wait(input logic [7:0] sa, output bit wrote_before);
    bit prev;
    prev = 1'b0;
    reg_addr = sa;
    for (int n = 0; n < 5000; n++) begin
      @(negedge clk);
      #1;
      if (reg_rdata[0]) break;
      prev = lut_we;
    end
    wrote_before = prev;
  endtask

  task automatic do_start(input logic [7:0] da, input logic [7:0] sa, input logic [31:0] addr);
    logic [31:0] s;
    rw(da, 32'd0);
    for (int n = 0; n < 200; n++) begin
      rr(sa, s);
      if (s[0]) break;
    end
    rw(da, addr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    bit wb;
    int wc;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rr(A_S0, v); chk(v == 32'h1, "R1 status0", v, 32'h1);
    rr(A_S1, v); chk(v == 32'h1, "R1 status1", v, 32'h1);
    rr(A_IST, v); chk(v == 32'h0, "R1 irq status", v, 32'h0);
    chk(irq == 1'b0, "R1 irq_o", 32'(irq), 32'h0);

    rw(A_IEN, 32'hFF);

    // two-descriptor chain on engine 0 (R2 R3 R4 R5 R6)
    mk_desc(32'h100, 32'h140, 1, 3, 5, 10, 11, 32'h400, 32'hA000_0000, 1'b1);
    mk_desc(32'h140, 32'h0,   2, 0, 0, 0, 2,    32'h480, 32'hB000_0000, 1'b1);
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h100);
    rr(A_S0, v); chk(v[0] == 1'b0, "R5 ready low while busy", v, 32'h0);
    run_wait(A_S0, wb);
    chk(wb, "R5 ready one cycle after last write", 32'(wb), 32'h1);
    chk(qlen() == 0, "R4 R2 chain followed, all entries written", 32'(qlen()), 32'h0);
    chk(wr_count - wc == 9, "R3 write count", 32'(wr_count - wc), 32'd9);
    rr(A_IST, v); chk(v == 32'h1, "R6 eol bit set", v, 32'h1);
    chk(irq == 1'b1, "R6 irq_o high", 32'(irq), 32'h1);
    rw(A_IST, 32'h1);
    rr(A_IST, v); chk(v == 32'h0, "R6 w1c clears", v, 32'h0);
    chk(irq == 1'b0, "R6 irq_o low after clear", 32'(irq), 32'h0);

    // R7 unaligned start pointer
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h108);
    repeat (3) @(negedge clk);
    rr(A_S0, v); chk(v == 32'h3, "R7 err+ready after bad start", v, 32'h3);
    rr(A_IST, v); chk(v == 32'h2, "R7 err irq bit, no eol", v, 32'h2);
    chk(wr_count == wc, "R7 no writes", 32'(wr_count - wc), 32'h0);
    rw(A_IST, 32'hFF);

    // R9 cancel clears ERR
    rw(A_D0, 32'h0);
    rr(A_S0, v); chk(v == 32'h1, "R9 cancel clears err", v, 32'h1);

    // R8 inverted area
    mk_desc(32'h180, 32'h0, 0, 5, 2, 0, 0, 32'h500, 32'h0, 1'b0);
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h180);
    run_wait(A_S0, wb);
    rr(A_S0, v); chk(v == 32'h3, "R8 err after inverted area", v, 32'h3);
    rr(A_IST, v); chk(v == 32'h2, "R8 err irq, no eol", v, 32'h2);
    chk(wr_count == wc, "R8 no writes", 32'(wr_count - wc), 32'h0);
    rw(A_IST, 32'hFF);

    // R7 unaligned data pointer
    mk_desc(32'h1C0, 32'h0, 0, 1, 1, 1, 1, 32'h504, 32'h0, 1'b0);
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h1C0);
    run_wait(A_S0, wb);
    rr(A_S0, v); chk(v == 32'h3, "R7 err after bad data pointer", v, 32'h3);
    chk(wr_count == wc, "R7 no writes for bad data pointer", 32'(wr_count - wc), 32'h0);
    rw(A_IST, 32'hFF);

    // R7 unaligned next pointer: first descriptor completes, then ERR
    mk_desc(32'h200, 32'h204, 0, 2, 2, 3, 3, 32'h540, 32'hC000_0000, 1'b1);
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h200);
    run_wait(A_S0, wb);
    rr(A_S0, v); chk(v == 32'h3, "R7 err after bad next pointer", v, 32'h3);
    chk(wr_count - wc == 1 && qlen() == 0, "R7 only first descriptor written", 32'(wr_count - wc), 32'h1);
    rr(A_IST, v); chk(v == 32'h2, "R7 no eol for bad next", v, 32'h2);
    rw(A_IST, 32'hFF);

    // R9 cancel mid-chain
    mk_desc(32'h240, 32'h0, 3, 0, 7, 0, 3, 32'h600, 32'h5000_0000, 1'b0);
    sb_on = 1'b0;
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h240);
    for (int n = 0; n < 2000 && wr_count < wc + 3; n++) @(negedge clk);
    rw(A_D0, 32'h0);
    #1 wc = wr_count;
    rr(A_S0, v); chk(v == 32'h1, "R9 ready after cancel", v, 32'h1);
    repeat (40) @(negedge clk);
    chk(wr_count == wc, "R9 no writes after cancel", 32'(wr_count - wc), 32'h0);
    rr(A_IST, v); chk(v == 32'h0, "R9 no eol after cancel", v, 32'h0);
    sb_on = 1'b1;

    // R10 start while busy is ignored
    mk_desc(32'h280, 32'h0, 0, 1, 2, 4, 4, 32'h700, 32'hD000_0000, 1'b1);
    wc = wr_count;
    do_start(A_D0, A_S0, 32'h280);
    rw(A_D0, 32'h100);
    run_wait(A_S0, wb);
    chk(wr_count - wc == 2, "R10 only original chain written", 32'(wr_count - wc), 32'd2);
    chk(qlen() == 0, "R10 expected entries drained", 32'(qlen()), 32'h0);
    rw(A_IST, 32'hFF);

    // R11 two engines concurrently
    mk_desc(32'h300, 32'h0,   0, 0, 3, 20, 21, 32'h800, 32'hE000_0000, 1'b1);
    mk_desc(32'h340, 32'h380, 1, 10, 11, 1, 2, 32'h880, 32'hF000_0000, 1'b1);
    mk_desc(32'h380, 32'h0,   1, 7, 7, 0, 0,   32'h8C0, 32'h1000_0000, 1'b1);
    do_start(A_D0, A_S0, 32'h300);
    do_start(A_D1, A_S1, 32'h340);
    for (int n = 0; n < 5000; n++) begin
      logic [31:0] s0, s1;
      rr(A_S0, s0);
      rr(A_S1, s1);
      if (s0[0] && s1[0]) break;
    end
    chk(qlen() == 0, "R11 both engines completed", 32'(qlen()), 32'h0);
    chk(dbl_req == 0, "R11 one read in flight", 32'(dbl_req), 32'h0);
    rr(A_IST, v); chk(v == 32'h11, "R6 R11 eol bits both engines", v, 32'h11);
    rw(A_IST, 32'hFF);

    // R12 enable gating
    rw(A_IEN, 32'h0);
    mk_desc(32'h280, 32'h0, 0, 1, 2, 4, 4, 32'h700, 32'hD100_0000, 1'b1);
    do_start(A_D0, A_S0, 32'h280);
    run_wait(A_S0, wb);
    repeat (2) @(negedge clk);
    rr(A_IST, v); chk(v == 32'h1, "R12 status recorded while disabled", v, 32'h1);
    chk(irq == 1'b0, "R12 irq_o masked", 32'(irq), 32'h0);
    rw(A_IEN, 32'h1);
    #1 chk(irq == 1'b1, "R12 irq_o after enable", 32'(irq), 32'h1);
    rw(A_IST, 32'h1);
    #1 chk(irq == 1'b0, "R12 irq_o after clear", 32'(irq), 32'h0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule